// File: doc/BRIEF.md
# Reload-Mode PWM Timer with Buffered Duty Update

This block is a 16-bit up-counting timer that produces a pulse-width-modulated waveform whose period stays fixed while its duty can be changed at any time. It does not compare a free-running counter against a duty value. It works in set-on-compare, clear-on-rollover form. When the counter equals the active compare value, the output goes high and the counter jumps to a programmable reload value. The counter then climbs to 65535 and rolls over to 0, and the output drops at that rollover. The low time is therefore the compare value plus one tick, and the high time is 65536 minus the reload value.

The compare value and the reload value are each written into a buffer register. The compare buffer is copied into the active compare value only on a match, and the reload value is consumed only on a match. A host can therefore update the duty in the middle of a period without producing a short or long pulse. A power-of-two prescaler sets the counting rate. A force select drives the pin constantly low for 0% duty or constantly high for 100% duty, and the counter keeps running while the pin is forced.

Top module: `pwm_reload_timer`

## Requirements
- R1: When enabled, the counter advances once every 2^n clock cycles, where n is the value on `prescaleSel` (0 to 7). The first advance after an initialise or reset falls on the 2^n-th enabled cycle.
- R2: On a tick where the counter equals the active compare value, the counter is loaded with the reload value instead of incrementing. This match takes priority over rollover.
- R3: The timer output goes to 1 on a compare match and to 0 on a tick that takes the counter from 65535 to 0. Otherwise it holds its value.
- R4: On a compare match, the active compare value (`compareOut`) is loaded from the compare buffer.
- R5: With compare buffer = P−d−1 and reload = 65536−d, and 0 < d < P, the steady-state output is high for d ticks and low for P−d ticks.
- R6: A write to either buffer in the same cycle as a compare match does not affect that match, which uses the old values. The new values take effect at the next match.
- R7: While `timerEnable` is 0, the counter and the timer output hold. Buffer writes are still accepted and change neither the counter nor the output.
- R8: A `cfgInit` pulse loads the counter from the reload value and the active compare from the compare buffer, clears the timer output and restarts the prescaler. It takes priority over counting.
- R9: `forceSel` = 2'b00 passes the timer output to `pwmOut`, 2'b01 drives it 0, and 2'b10 or 2'b11 drives it 1. Forcing does not stop the counter.
- R10: After reset, the counter, the active compare, both buffers and the output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerEnable | input | 1 | Run bit for this timer |
| prescaleSel | input | 3 | Prescaler exponent n; rate is clk / 2^n |
| cfgInit | input | 1 | Initialise pulse: counter from reload value, compare from buffer |
| cmpLdWr | input | 1 | Write strobe for the compare buffer |
| cmpLdData | input | 16 | Compare buffer write data |
| loadWr | input | 1 | Write strobe for the reload value |
| loadData | input | 16 | Reload value write data |
| forceSel | input | 2 | 00 timer output, 01 force low, 1x force high |
| pwmOut | output | 1 | PWM pin |
| countOut | output | 16 | Current counter value |
| compareOut | output | 16 | Active compare value |

## Verification
The counter, the active compare value and the timer output are registered, so each one changes exactly one clock edge after the cycle in which a tick, a match, a rollover or an initialise is decided. Buffer writes become visible only through a later match or initialise. `pwmOut` follows `forceSel` in the same cycle. The bench drives inputs at the falling edge, and it compares the design with its expected state at the next falling edge, after exactly one rising edge. For the coincident-write, prescaler and duty cases, the bench counts ticks itself and checks the value due at that point.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic init;     // configure: counter <= reload, compare <= buffer
    logic tick;     // prescaled counting event
    logic doMatch;  // tick with counter equal to active compare
    logic doWrap;   // tick with counter at its maximum and no match
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timerEnable,
  input  logic [PRE_W-1:0] prescaleSel,
  input  logic             cfgInit,
  input  logic             cntAtCmp,
  input  logic             cntAtMax,
  output pwmStrobe_t       strobe
);

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] divMask;
  logic             tickRaw;

  // Mask of low prescaler bits that must all be 1 for a tick
  for (genvar i = 0; i < DIV_W; i++) begin : gMask
    assign divMask[i] = (prescaleSel > PRE_W'(i));
  end

  assign tickRaw = ((preCnt & divMask) == divMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (cfgInit) begin
      preCnt <= '0;
    end else if (timerEnable) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.init    = cfgInit;
    strobe.tick    = timerEnable && !cfgInit && tickRaw;
    strobe.doMatch = strobe.tick && cntAtCmp;
    strobe.doWrap  = strobe.tick && !cntAtCmp && cntAtMax;
  end

  // R1: a stopped timer never produces a counting event
  a_r1_no_tick_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !timerEnable |-> !strobe.tick);

  // R1: with a divider of two or more, ticks are never back to back
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && prescaleSel != '0) |=> (prescaleSel == '0 || !strobe.tick));

endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic             cmpLdWr,
  input  logic [CNT_W-1:0] cmpLdData,
  input  logic             loadWr,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] compareNow,
  output logic             timerOut,
  output logic             cntAtCmp,
  output logic             cntAtMax
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cmpLdReg;
  logic [CNT_W-1:0] loadReg;

  assign cntAtCmp = (count == compareNow);
  assign cntAtMax = (count == CNT_MAX);

  // Buffer registers: written at any time, consumed only on match or init
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpLdReg <= '0;
      loadReg  <= '0;
    end else begin
      if (cmpLdWr) cmpLdReg <= cmpLdData;
      if (loadWr)  loadReg  <= loadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      compareNow <= '0;
      timerOut   <= 1'b0;
    end else if (strobe.init) begin
      count      <= loadReg;
      compareNow <= cmpLdReg;
      timerOut   <= 1'b0;
    end else if (strobe.doMatch) begin
      count      <= loadReg;
      compareNow <= cmpLdReg;
      timerOut   <= 1'b1;
    end else if (strobe.doWrap) begin
      count      <= '0;
      timerOut   <= 1'b0;
    end else if (strobe.tick) begin
      count      <= count + 1'b1;
    end
  end

  // R2: a match reloads the counter from the reload value held before the edge
  a_r2_reload_on_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doMatch |=> count == $past(loadReg));

  // R4: a match copies the compare buffer into the active compare
  a_r4_compare_transfer: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doMatch |=> compareNow == $past(cmpLdReg));

  // R3: output set by match, cleared with the counter by rollover
  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doMatch |=> timerOut);

  a_r3_clear_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrap |=> (!timerOut && count == '0));

  // R3: output moves only on match, rollover or initialise
  a_r3_out_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doMatch && !strobe.doWrap && !strobe.init) |=> $stable(timerOut));

  // R7: without a tick or initialise the counter holds
  a_r7_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.init) |=> $stable(count));

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        timerEnable,
  input  logic [2:0]  prescaleSel,
  input  logic        cfgInit,
  input  logic        cmpLdWr,
  input  logic [15:0] cmpLdData,
  input  logic        loadWr,
  input  logic [15:0] loadData,
  input  logic [1:0]  forceSel,
  output logic        pwmOut,
  output logic [15:0] countOut,
  output logic [15:0] compareOut
);

  localparam int CNT_W = 16;
  localparam int PRE_W = 3;

  pwmStrobe_t strobe;
  logic       cntAtCmp;
  logic       cntAtMax;
  logic       timerOut;

  pwm_timer_ctrl #(.PRE_W(PRE_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .timerEnable (timerEnable),
    .prescaleSel (prescaleSel),
    .cfgInit     (cfgInit),
    .cntAtCmp    (cntAtCmp),
    .cntAtMax    (cntAtMax),
    .strobe      (strobe)
  );

  pwm_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmpLdWr    (cmpLdWr),
    .cmpLdData  (cmpLdData),
    .loadWr     (loadWr),
    .loadData   (loadData),
    .count      (countOut),
    .compareNow (compareOut),
    .timerOut   (timerOut),
    .cntAtCmp   (cntAtCmp),
    .cntAtMax   (cntAtMax)
  );

  // Pin override: high select wins over low select
  assign pwmOut = forceSel[1] ? 1'b1 : (forceSel[0] ? 1'b0 : timerOut);

endmodule

// File: tb/tb_pwm_reload_timer.sv
module tb_pwm_reload_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timerEnable = 1'b0;
  logic [2:0]  prescaleSel = 3'd0;
  logic        cfgInit = 1'b0;
  logic        cmpLdWr = 1'b0;
  logic [15:0] cmpLdData = 16'd0;
  logic        loadWr = 1'b0;
  logic [15:0] loadData = 16'd0;
  logic [1:0]  forceSel = 2'b00;
  logic        pwmOut;
  logic [15:0] countOut;
  logic [15:0] compareOut;

  int checks = 0;
  int errors = 0;

  // expected state, derived from the requirements
  logic [15:0] mCnt, mCmp, mCmpLd, mLd;
  logic        mOut;
  logic [6:0]  mPre;

  always #10 clk = ~clk;

  pwm_reload_timer dut (
    .clk(clk), .rstN(rstN), .timerEnable(timerEnable), .prescaleSel(prescaleSel),
    .cfgInit(cfgInit), .cmpLdWr(cmpLdWr), .cmpLdData(cmpLdData), .loadWr(loadWr),
    .loadData(loadData), .forceSel(forceSel), .pwmOut(pwmOut), .countOut(countOut),
    .compareOut(compareOut)
  );

  function automatic logic expPin(logic [1:0] f, logic o);
    if (f[1]) return 1'b1;
    if (f[0]) return 1'b0;
    return o;
  endfunction

  function automatic logic tickDue(logic [6:0] pre, logic [2:0] n);
    logic [6:0] m;
    m = 7'((8'd1 << n) - 8'd1);
    return (pre & m) == m;
  endfunction

  // Expected-state update at each rising edge (R1 R2 R3 R4 R6 R7 R8 R10)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mCmpLd = 0; mLd = 0; mOut = 0; mPre = 0;
    end else begin
      if (cfgInit) begin
        mCnt = mLd; mCmp = mCmpLd; mOut = 0; mPre = 0;
      end else if (timerEnable) begin
        if (tickDue(mPre, prescaleSel)) begin
          if (mCnt == mCmp) begin
            mCnt = mLd; mCmp = mCmpLd; mOut = 1;
          end else if (mCnt == 16'hFFFF) begin
            mCnt = 0; mOut = 0;
          end else begin
            mCnt = mCnt + 1;
          end
        end
        mPre = mPre + 1;
      end
      if (cmpLdWr) mCmpLd = cmpLdData;
      if (loadWr)  mLd = loadData;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: wait for the falling edge after a rising edge, compare against expected
  task automatic step();
    @(negedge clk);
    check(countOut == mCnt, "R2 R3 R4 count", countOut, mCnt);
    check(compareOut == mCmp, "R4 compare", compareOut, mCmp);
    check(pwmOut == expPin(forceSel, mOut), "R3 R9 pin", pwmOut, expPin(forceSel, mOut));
  endtask

  task automatic writeBuf(input logic [15:0] c, input logic [15:0] l);
    cmpLdWr = 1; cmpLdData = c; loadWr = 1; loadData = l;
    step();
    cmpLdWr = 0; loadWr = 0;
  endtask

  task automatic doInit();
    cfgInit = 1;
    step();
    cfgInit = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    logic        p0, prevPin;
    int          run, lastHigh, lastLow, guard;

    repeat (3) @(negedge clk);
    // R10: reset state
    check(countOut == 0, "R10 count", countOut, 0);
    check(compareOut == 0, "R10 compare", compareOut, 0);
    check(pwmOut == 0, "R10 pin", pwmOut, 0);
    rstN = 1;
    step();

    // R1: prescaler of 8, no match or rollover in range
    writeBuf(16'hFFFF, 16'h0000);
    prescaleSel = 3'd3;
    doInit();
    timerEnable = 1;
    repeat (64) step();
    check(countOut == 16'd8, "R1 prescale 8", countOut, 8);

    // R5: period 40, duty 10
    timerEnable = 0; prescaleSel = 3'd0;
    writeBuf(16'd29, 16'd65526);
    doInit();
    timerEnable = 1;
    prevPin = pwmOut; run = 0; lastHigh = -1; lastLow = -1;
    for (int i = 0; i < 200; i++) begin
      step();
      run++;
      if (pwmOut != prevPin) begin
        if (prevPin) lastHigh = run; else lastLow = run;
        run = 0;
        prevPin = pwmOut;
      end
    end
    check(lastHigh == 10, "R5 high ticks", lastHigh, 10);
    check(lastLow == 30, "R5 low ticks", lastLow, 30);

    // R6: buffer write coincident with a match
    timerEnable = 0;
    writeBuf(16'd5, 16'hFFF0);
    doInit();
    timerEnable = 1;
    guard = 0;
    while (countOut != compareOut && guard < 200) begin step(); guard++; end
    cmpLdWr = 1; cmpLdData = 16'd7; loadWr = 1; loadData = 16'hFFF8;
    step();
    cmpLdWr = 0; loadWr = 0;
    check(countOut == 16'hFFF0, "R6 old reload used", countOut, 16'hFFF0);
    check(compareOut == 16'd5, "R6 old compare used", compareOut, 5);
    guard = 0;
    while (countOut != compareOut && guard < 200) begin step(); guard++; end
    step();
    check(countOut == 16'hFFF8, "R6 new reload at next match", countOut, 16'hFFF8);
    check(compareOut == 16'd7, "R6 new compare at next match", compareOut, 7);

    // R7: stopped timer holds, buffer writes accepted without effect
    timerEnable = 0;
    step();
    c0 = countOut; p0 = pwmOut;
    repeat (20) step();
    writeBuf(16'h1234, 16'h4321);
    step();
    check(countOut == c0, "R7 count held", countOut, c0);
    check(pwmOut == p0, "R7 pin held", pwmOut, p0);
    // R8: initialise brings buffered values out
    doInit();
    check(countOut == 16'h4321, "R8 init count", countOut, 16'h4321);
    check(compareOut == 16'h1234, "R8 init compare", compareOut, 16'h1234);
    check(pwmOut == 0, "R8 init clears output", pwmOut, 0);

    // R9: force low/high while counting
    timerEnable = 1;
    c0 = countOut;
    forceSel = 2'b01; step();
    check(pwmOut == 0, "R9 force low", pwmOut, 0);
    forceSel = 2'b10; step();
    check(pwmOut == 1, "R9 force high", pwmOut, 1);
    forceSel = 2'b11; step();
    check(pwmOut == 1, "R9 force high wins", pwmOut, 1);
    check(countOut == c0 + 16'd3, "R9 counter runs while forced", countOut, c0 + 16'd3);
    forceSel = 2'b00;

    // Random mix against expected state (R1 R2 R3 R4 R6 R7 R8 R9)
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      timerEnable = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 49) == 0) prescaleSel = 3'($urandom_range(0, 2));
      cmpLdWr   = ($urandom_range(0, 7) == 0);
      cmpLdData = 16'($urandom_range(0, 20));
      loadWr    = ($urandom_range(0, 7) == 0);
      loadData  = 16'hFFF0 + 16'($urandom_range(0, 15));
      cfgInit   = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 29) == 0) forceSel = 2'($urandom_range(0, 3));
      step();
    end
    cmpLdWr = 0; loadWr = 0; cfgInit = 0;
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule